// File: doc/BRIEF.md
# Coarse/Fine Time-to-Digital Converter Decoder

This block is the digital back end of a two-step time-to-digital converter. A long delay chain, split into four equal sections of eight cells, and a short eight-cell chain are outside the block. The block receives their sampled tap states as thermometer vectors and turns them into a period code for the measured reference signal.

A conversion is armed by the enable input. The first falling edge of the reference after arming freezes the coarse vector and decodes it into a section select. That select is driven out so that an external multiplexer can route the chosen section into the short chain. One cycle later the fine vector is decoded into a fine select, and one cycle after that the period code (section × 8 + fine) × 2 is published with a single-cycle done pulse. The result then holds until a new conversion is armed.

Thermometer vectors are read from bit 0 upward: the decoded value is the number of consecutive ones starting at bit 0. A zero followed by a higher one (a bubble) is tolerated but flagged. A coarse vector with no bit set marks an out-of-range measurement.

Top module: `tdc2_top`

## Requirements
- R1: After reset, `done`, `overflow` and `bubbleErr` are 0 and `periodCode` and `muxSel` are 0.
- R2: While `convEn` is 0 and no conversion is in progress, falling edges of `refIn` cause no `done` pulse and leave `periodCode` unchanged.
- R3: A conversion is armed in the first cycle `convEn` is seen high from idle. The first cycle `refIn` is seen low after having been seen high while armed is the edge cycle; at the clock edge ending it, `muxSel` takes the count of consecutive ones of `coarseTherm` from bit 0, minus one (bit 0 is the earliest section).
- R4: At the next clock edge the fine select is taken as the count of consecutive ones of `fineTherm` from bit 0, capped at 7.
- R5: At the clock edge after that, `periodCode` becomes (section × 8 + fine) × 2 and `done` is 1 for that cycle.
- R6: `done` lasts exactly one cycle; `periodCode` and `muxSel` hold their values until the next conversion is armed, which clears them and `overflow`.
- R7: A thermometer vector with a 0 below a 1 is decoded from its leading ones only, and `bubbleErr` is set and stays set until reset.
- R8: If `coarseTherm` is all zero in the edge cycle, at the clock edge ending it `overflow` becomes 1, `periodCode` becomes 127 and `done` pulses; no fine step follows.
- R9: Deasserting `convEn` before the reference edge cancels the conversion: no `done` pulse follows.
- R10: After `done`, further `refIn` edges and input changes are ignored until `convEn` is taken low and high again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| convEn | input | 1 | Conversion enable |
| refIn | input | 1 | Measured reference, synchronous samples |
| coarseTherm | input | 4 | Sampled section outputs, thermometer code |
| fineTherm | input | 8 | Sampled short-chain outputs, thermometer code |
| muxSel | output | 2 | Section select to the section multiplexer |
| periodCode | output | 7 | Measured period code |
| done | output | 1 | One-cycle result-valid pulse |
| overflow | output | 1 | Coarse vector was empty; period saturated |
| bubbleErr | output | 1 | Sticky thermometer bubble flag |

## Verification
A sequencer stuck in the wrong step shows up as a `done` pulse arriving early, late, twice, or not at all, so every run checks the exact cycle of `done` relative to the reference edge. A section select latched from the wrong cycle or decoded with an off-by-one error appears on `muxSel` one cycle after the edge and in `periodCode` two cycles later; a lost clear appears as a stale `overflow` or period when the next conversion is armed. Bubble, empty-vector and full-vector codes are driven to expose decoding at its edges.

// File: rtl/tdc2_pkg.sv
package tdc2_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_WAIT,
    ST_FINE,
    ST_CALC,
    ST_HOLD
  } tdcState_t;

  // Strobes from the sequencer to the datapath
  typedef struct packed {
    logic clear;      // new conversion armed
    logic capCoarse;  // reference edge seen: latch section select
    logic capFine;    // latch fine select
    logic calc;       // publish period code
  } tdcStrobe_t;

endpackage

// File: rtl/tdc2_therm_dec.sv
module tdc2_therm_dec #(
  parameter int W = 8,
  localparam int CW = $clog2(W + 1)
) (
  input  logic [W-1:0]  therm,
  output logic [CW-1:0] ones,
  output logic          bubble
);

  logic seenZero;

  // Count consecutive ones from bit 0; any one above a zero is a bubble
  always_comb begin
    ones     = '0;
    bubble   = 1'b0;
    seenZero = 1'b0;
    for (int i = 0; i < W; i++) begin
      if (!therm[i]) begin
        seenZero = 1'b1;
      end else if (seenZero) begin
        bubble = 1'b1;
      end else begin
        ones = CW'(i + 1);
      end
    end
  end

endmodule

// File: rtl/tdc2_ctrl.sv
module tdc2_ctrl
  import tdc2_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       convEn,
  input  logic       refIn,
  input  logic       coarseEmpty,
  output tdcStrobe_t strobe
);

  tdcState_t state, stateNext;
  logic      refPrev;
  logic      fallEdge;

  assign fallEdge = refPrev & ~refIn;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state   <= ST_IDLE;
      refPrev <= 1'b0;
    end else begin
      state   <= stateNext;
      refPrev <= refIn;
    end
  end

  always_comb begin
    stateNext = state;
    strobe    = '0;
    unique case (state)
      ST_IDLE: begin
        if (convEn) begin
          strobe.clear = 1'b1;
          stateNext    = ST_WAIT;
        end
      end
      ST_WAIT: begin
        if (!convEn) begin
          stateNext = ST_IDLE;
        end else if (fallEdge) begin
          strobe.capCoarse = 1'b1;
          stateNext        = coarseEmpty ? ST_HOLD : ST_FINE;
        end
      end
      ST_FINE: begin
        strobe.capFine = 1'b1;
        stateNext      = ST_CALC;
      end
      ST_CALC: begin
        strobe.calc = 1'b1;
        stateNext   = ST_HOLD;
      end
      ST_HOLD: begin
        if (!convEn) stateNext = ST_IDLE;
      end
      default: stateNext = ST_IDLE;
    endcase
  end

endmodule

// File: rtl/tdc2_datapath.sv
module tdc2_datapath
  import tdc2_pkg::*;
#(
  parameter int SECTIONS = 4,
  parameter int CELLS    = 8,
  parameter int PERIOD_W = 7,
  localparam int SEL_W  = $clog2(SECTIONS),
  localparam int FINE_W = $clog2(CELLS),
  localparam int CCW    = $clog2(SECTIONS + 1),
  localparam int FCW    = $clog2(CELLS + 1)
) (
  input  logic                clk,
  input  logic                rstN,
  input  tdcStrobe_t          strobe,
  input  logic [SECTIONS-1:0] coarseTherm,
  input  logic [CELLS-1:0]    fineTherm,
  output logic                coarseEmpty,
  output logic [SEL_W-1:0]    sectSel,
  output logic [PERIOD_W-1:0] periodCode,
  output logic                done,
  output logic                overflow,
  output logic                bubbleErr
);

  logic [CCW-1:0]      coarseOnes;
  logic [FCW-1:0]      fineOnes;
  logic                coarseBubble;
  logic                fineBubble;
  logic [FINE_W-1:0]   fineSel;
  logic [SEL_W-1:0]    sectNext;
  logic [FINE_W-1:0]   fineNext;
  logic [PERIOD_W-1:0] periodNext;

  tdc2_therm_dec #(.W(SECTIONS)) u_coarseDec (
    .therm (coarseTherm),
    .ones  (coarseOnes),
    .bubble(coarseBubble)
  );

  tdc2_therm_dec #(.W(CELLS)) u_fineDec (
    .therm (fineTherm),
    .ones  (fineOnes),
    .bubble(fineBubble)
  );

  assign coarseEmpty = (coarseOnes == '0);
  assign sectNext    = SEL_W'(coarseOnes - CCW'(1));
  assign fineNext    = (fineOnes > FCW'(CELLS - 1)) ? FINE_W'(CELLS - 1) : FINE_W'(fineOnes);
  assign periodNext  = PERIOD_W'((PERIOD_W'(sectSel) * PERIOD_W'(CELLS)
                                  + PERIOD_W'(fineSel)) * PERIOD_W'(2));

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sectSel    <= '0;
      fineSel    <= '0;
      periodCode <= '0;
      done       <= 1'b0;
      overflow   <= 1'b0;
      bubbleErr  <= 1'b0;
    end else begin
      done <= 1'b0;
      if (strobe.clear) begin
        sectSel    <= '0;
        fineSel    <= '0;
        periodCode <= '0;
        overflow   <= 1'b0;
      end
      if (strobe.capCoarse) begin
        if (coarseEmpty) begin
          overflow   <= 1'b1;
          periodCode <= '1;
          done       <= 1'b1;
        end else begin
          sectSel <= sectNext;
        end
        if (coarseBubble) bubbleErr <= 1'b1;
      end
      if (strobe.capFine) begin
        fineSel <= fineNext;
        if (fineBubble) bubbleErr <= 1'b1;
      end
      if (strobe.calc) begin
        periodCode <= periodNext;
        done       <= 1'b1;
      end
    end
  end

endmodule

// File: rtl/tdc2_top.sv
module tdc2_top
  import tdc2_pkg::*;
#(
  parameter int SECTIONS = 4,
  parameter int CELLS    = 8,
  parameter int PERIOD_W = 7,
  localparam int SEL_W = $clog2(SECTIONS)
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                convEn,
  input  logic                refIn,
  input  logic [SECTIONS-1:0] coarseTherm,
  input  logic [CELLS-1:0]    fineTherm,
  output logic [SEL_W-1:0]    muxSel,
  output logic [PERIOD_W-1:0] periodCode,
  output logic                done,
  output logic                overflow,
  output logic                bubbleErr
);

  tdcStrobe_t strobe;
  logic       coarseEmpty;

  tdc2_ctrl u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .convEn     (convEn),
    .refIn      (refIn),
    .coarseEmpty(coarseEmpty),
    .strobe     (strobe)
  );

  tdc2_datapath #(
    .SECTIONS(SECTIONS),
    .CELLS   (CELLS),
    .PERIOD_W(PERIOD_W)
  ) u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .strobe     (strobe),
    .coarseTherm(coarseTherm),
    .fineTherm  (fineTherm),
    .coarseEmpty(coarseEmpty),
    .sectSel    (muxSel),
    .periodCode (periodCode),
    .done       (done),
    .overflow   (overflow),
    .bubbleErr  (bubbleErr)
  );

endmodule

// File: rtl/tdc2_chk.sv
module tdc2_chk #(
  parameter int SECTIONS = 4,
  parameter int CELLS    = 8,
  parameter int PERIOD_W = 7,
  localparam int SEL_W   = $clog2(SECTIONS),
  localparam int MAX_VAL = ((SECTIONS - 1) * CELLS + CELLS - 1) * 2
) (
  input logic                clk,
  input logic                rstN,
  input logic                convEn,
  input logic [SEL_W-1:0]    muxSel,
  input logic [PERIOD_W-1:0] periodCode,
  input logic                done,
  input logic                overflow,
  input logic                bubbleErr
);

  // R6
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);

  // R8
  ovf_sat_chk: assert property (@(posedge clk) disable iff (!rstN)
    (done && overflow) |-> (periodCode == {PERIOD_W{1'b1}}));

  // R8
  ovf_with_done_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(overflow) |-> done);

  // R5
  period_range_chk: assert property (@(posedge clk) disable iff (!rstN)
    (done && !overflow) |-> (!periodCode[0] && (int'(periodCode) <= MAX_VAL)));

  // R7
  bubble_sticky_chk: assert property (@(posedge clk) disable iff (!rstN)
    bubbleErr |=> bubbleErr);

  // R3
  sel_settled_chk: assert property (@(posedge clk) disable iff (!rstN)
    (done && !overflow) |-> $stable(muxSel));

  // R6
  period_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!convEn && !done) |=> ($stable(periodCode) || done));

endmodule

bind tdc2_top tdc2_chk #(
  .SECTIONS(SECTIONS),
  .CELLS   (CELLS),
  .PERIOD_W(PERIOD_W)
) u_chk (
  .clk       (clk),
  .rstN      (rstN),
  .convEn    (convEn),
  .muxSel    (muxSel),
  .periodCode(periodCode),
  .done      (done),
  .overflow  (overflow),
  .bubbleErr (bubbleErr)
);

// File: tb/tdc2_top_bench.sv
module tdc2_top_bench;

  logic       clk = 1'b0;
  logic       rstN;
  logic       convEn;
  logic       refIn;
  logic [3:0] coarseTherm;
  logic [7:0] fineTherm;
  logic [1:0] muxSel;
  logic [6:0] periodCode;
  logic       done;
  logic       overflow;
  logic       bubbleErr;

  int checks   = 0;
  int failures = 0;
  int doneCount = 0;

  always #4 clk = ~clk;

  tdc2_top u_tdc2_top (
    .clk        (clk),
    .rstN       (rstN),
    .convEn     (convEn),
    .refIn      (refIn),
    .coarseTherm(coarseTherm),
    .fineTherm  (fineTherm),
    .muxSel     (muxSel),
    .periodCode (periodCode),
    .done       (done),
    .overflow   (overflow),
    .bubbleErr  (bubbleErr)
  );

  always @(negedge clk) if (done) doneCount++;

  task automatic check(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic applyReset();
    rstN = 1'b0; convEn = 1'b0; refIn = 1'b1;
    coarseTherm = '0; fineTherm = '0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
  endtask

  // Arm, then present a falling edge; ends in the edge cycle
  task automatic armAndFall(input logic [3:0] c, input logic [7:0] f);
    @(negedge clk);
    coarseTherm = c; fineTherm = f; refIn = 1'b1; convEn = 1'b1;
    repeat (2) @(negedge clk);
    refIn = 1'b0;
  endtask

  task automatic endConv();
    @(negedge clk);
    convEn = 1'b0; refIn = 1'b1;
    repeat (2) @(negedge clk);
  endtask

  task automatic runConv(input logic [3:0] c, input logic [7:0] f,
                         input int expSel, input int expPer, input string tag);
    int base;
    armAndFall(c, f);
    base = doneCount;
    @(posedge clk); #1;
    check({tag, " R3 muxSel"}, muxSel, expSel);
    check({tag, " R3 no early done"}, done, 0);
    @(posedge clk); #1;
    check({tag, " R4 fine step no done"}, done, 0);
    @(posedge clk); #1;
    check({tag, " R5 done"}, done, 1);
    check({tag, " R5 period"}, periodCode, expPer);
    check({tag, " R8 no overflow"}, overflow, 0);
    @(posedge clk); #1;
    check({tag, " R6 done one cycle"}, done, 0);
    check({tag, " R6 period held"}, periodCode, expPer);
    check({tag, " R6 single pulse"}, doneCount - base, 1);
  endtask

  task automatic testReset();
    applyReset();
    check("R1 done", done, 0);
    check("R1 overflow", overflow, 0);
    check("R1 bubbleErr", bubbleErr, 0);
    check("R1 periodCode", periodCode, 0);
    check("R1 muxSel", muxSel, 0);
  endtask

  task automatic testNoEnable();
    int base = doneCount;
    for (int i = 0; i < 4; i++) begin
      @(negedge clk); refIn = 1'b0; coarseTherm = 4'b0011;
      @(negedge clk); refIn = 1'b1;
    end
    repeat (3) @(negedge clk);
    check("R2 no done without enable", doneCount - base, 0);
    check("R2 period untouched", periodCode, 0);
  endtask

  task automatic testIgnoreAfterDone();
    int base;
    runConv(4'b0111, 8'h1F, 2, 42, "held");
    base = doneCount;
    for (int i = 0; i < 3; i++) begin
      @(negedge clk); refIn = 1'b1; coarseTherm = 4'b0001; fineTherm = 8'h00;
      @(negedge clk); refIn = 1'b0;
    end
    repeat (3) @(negedge clk);
    check("R10 no extra done", doneCount - base, 0);
    check("R10 period kept", periodCode, 42);
    check("R10 muxSel kept", muxSel, 2);
    endConv();
  endtask

  task automatic testAbort();
    int base;
    @(negedge clk);
    coarseTherm = 4'b0011; fineTherm = 8'h03; refIn = 1'b1; convEn = 1'b1;
    repeat (2) @(negedge clk);
    convEn = 1'b0;
    base = doneCount;
    @(negedge clk); refIn = 1'b0;
    repeat (5) @(negedge clk);
    check("R9 aborted no done", doneCount - base, 0);
    refIn = 1'b1;
    @(negedge clk);
  endtask

  task automatic testOverflow();
    armAndFall(4'b0000, 8'hFF);
    @(posedge clk); #1;
    check("R8 done at edge+1", done, 1);
    check("R8 overflow", overflow, 1);
    check("R8 saturated period", periodCode, 127);
    @(posedge clk); #1;
    check("R8 single done", done, 0);
    check("R8 overflow held", overflow, 1);
    endConv();
    @(negedge clk); convEn = 1'b1;
    @(negedge clk);
    check("R6 rearm clears overflow", overflow, 0);
    check("R6 rearm clears period", periodCode, 0);
    endConv();
  endtask

  task automatic testBubble();
    applyReset();
    runConv(4'b0101, 8'h07, 0, 6, "coarse bubble");
    check("R7 coarse bubble flagged", bubbleErr, 1);
    endConv();
    runConv(4'b0011, 8'h1F, 1, 26, "after bubble");
    check("R7 flag sticky", bubbleErr, 1);
    endConv();
    applyReset();
    runConv(4'b0001, 8'h03, 0, 4, "no bubble");
    check("R7 clean code no flag", bubbleErr, 0);
    endConv();
    runConv(4'b0011, 8'b0000_1011, 1, 20, "fine bubble");
    check("R7 fine bubble flagged", bubbleErr, 1);
    endConv();
  endtask

  initial begin
    fork
      begin
        testReset();
        testNoEnable();
        runConv(4'b0111, 8'h1F, 2, 42, "mid");
        endConv();
        runConv(4'b1111, 8'hFF, 3, 62, "R4 full cap");
        endConv();
        runConv(4'b0001, 8'h00, 0, 0, "R4 zero fine");
        endConv();
        testIgnoreAfterDone();
        testAbort();
        testOverflow();
        testBubble();
      end
      begin
        repeat (20000) @(posedge clk);
        failures++;
        $display("FAIL watchdog expired");
      end
    join_any
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule